// File: doc/BRIEF.md
# Single-to-Brain-Float Narrowing Converter

This unit takes a 32-bit single-precision value and produces its 16-bit brain-float equivalent, rounded under one of five rounding modes. The operand arrives in the low 32 bits of a wider register word. When the box check is enabled, that word is first tested for correct NaN boxing. The conversion is accepted on a valid strobe and registered, so the result and the exception flags appear one clock later.

The two formats share the same 8-bit exponent with bias 127. Narrowing therefore only cuts the significand from 24 to 8 bits. A carry out of the significand may step the exponent up, which can create an overflow to infinity or lift a subnormal into the smallest normal. Underflow uses after-rounding tininess: a second rounding is done as if the exponent range had no lower bound, and it decides whether the value counts as tiny. Every NaN result is the single canonical quiet pattern.

Top module: `bf16_narrow_cvt`

## Requirements
- R1: The result places the sign in bit 15, the biased exponent (bias 127) in bits 14:7 and the fraction in bits 6:0. For finite inputs the kept bits are input bits 30:16. Input bit 15 is the guard bit and the OR of bits 14:0 is the sticky bit.
- R2: Rounding codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest with ties away from zero. Code 111 uses `dynMode` instead. A resolved code of 101, 110 or 111 raises `illegalMode` and holds all five flags low.
- R3: On overflow, both nearest modes give infinity. A directed mode gives infinity when it rounds away from zero for that sign; otherwise it gives the largest finite magnitude 0x7F7F with the sign. Overflow and inexact are both raised.
- R4: Subnormal inputs give subnormal results and are never flushed to zero. They are rounded at the same bit positions, and a carry may produce the smallest normal 0x0080.
- R5: A result is tiny unless the value, rounded to 8 significant bits with no lower exponent bound, reaches 2^-126. Underflow is raised only when the result is both tiny and inexact.
- R6: Any NaN input gives 0x7FC0. A signalling NaN (exponent all ones, bit 22 clear, fraction nonzero) raises invalid. A quiet NaN raises no flag.
- R7: Zeros and infinities pass through with their sign (0x0000, 0x8000, 0x7F80, 0xFF80) and raise no flag.
- R8: Inexact is raised whenever input bits 15:0 of a finite nonzero input are not all zero.
- R9: The divide-by-zero flag is always 0.
- R10: With `boxCheckEn` high and `inData` bits above 31 not all ones, the operand is taken as the canonical quiet NaN (result 0x7FC0, no flags). With `boxCheckEn` low, those upper bits have no effect.
- R11: Reset clears `outValid`, the result and the flags. The result appears one cycle after `inValid`. `outValid` follows `inValid` with one cycle delay, and the outputs hold while `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| inData | input | REG_W | Register word, operand in bits 31:0 |
| boxCheckEn | input | 1 | Enable NaN-box check of the upper bits |
| rmField | input | 3 | Rounding code, 111 selects dynamic |
| dynMode | input | 3 | Dynamic rounding code |
| outValid | output | 1 | Result strobe |
| outResult | output | 16 | Brain-float result |
| flagInvalid | output | 1 | Invalid operation |
| flagDivZero | output | 1 | Divide by zero (constant 0) |
| flagOverflow | output | 1 | Overflow |
| flagUnderflow | output | 1 | Underflow |
| flagInexact | output | 1 | Inexact |
| illegalMode | output | 1 | Resolved rounding code is not defined |

## Verification
The hardest situation to reach is the narrow band just below 2^-126. There the bounded rounding carries into 0x0080, while the unbounded rounding may or may not reach 2^-126, and that choice decides whether underflow is raised. Random operands almost never land in it. The stimulus therefore has a category that fills fraction bits 22:15 with ones and randomises only the lower bits and the sign, under all five modes. Directed vectors such as 0x007F8000 and 0x007FC000 pin both outcomes.

// File: rtl/bfcvt_pkg.sv
package bfcvt_pkg;
  localparam int SRC_W      = 32;
  localparam int EXP_W      = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_FRAC_W = 7;
  localparam int DST_W      = 1 + EXP_W + DST_FRAC_W;
  localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_TO_ZERO   = 3'b001,
    RM_DOWN      = 3'b010,
    RM_UP        = 3'b011,
    RM_NEAR_MAX  = 3'b100,
    RM_DYNAMIC   = 3'b111
  } roundCode_e;

  typedef struct packed {
    logic modeRne;
    logic modeRtz;
    logic modeRdn;
    logic modeRup;
    logic modeRmm;
    logic illegal;
    logic boxFail;
  } cvtCtrl_t;
endpackage

// File: rtl/bfcvt_control.sv
module bfcvt_control
  import bfcvt_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] inData,
  input  logic             boxCheckEn,
  input  logic [2:0]       rmField,
  input  logic [2:0]       dynMode,
  output cvtCtrl_t         ctrl
);
  logic [2:0] effMode;
  logic       boxBad;

  always_comb begin
    effMode = (rmField == RM_DYNAMIC) ? dynMode : rmField;
  end

  generate
    if (REG_W > SRC_W) begin : g_box
      always_comb boxBad = boxCheckEn && !(&inData[REG_W-1:SRC_W]);
    end else begin : g_nobox
      logic unusedBits;
      always_comb unusedBits = ^inData ^ boxCheckEn;
      always_comb boxBad = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl.modeRne = (effMode == RM_NEAR_EVEN);
    ctrl.modeRtz = (effMode == RM_TO_ZERO);
    ctrl.modeRdn = (effMode == RM_DOWN);
    ctrl.modeRup = (effMode == RM_UP);
    ctrl.modeRmm = (effMode == RM_NEAR_MAX);
    ctrl.illegal = (effMode > RM_NEAR_MAX);
    ctrl.boxFail = boxBad;
  end
endmodule

// File: rtl/bfcvt_datapath.sv
module bfcvt_datapath
  import bfcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SRC_W-1:0] operand,
  input  cvtCtrl_t         ctrl,
  output logic             outValid,
  output logic [DST_W-1:0] outResult,
  output logic             flagInvalid,
  output logic             flagOverflow,
  output logic             flagUnderflow,
  output logic             flagInexact,
  output logic             illegalMode
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [SRC_W-1:0] SRC_QNAN = {1'b0, EXP_ONES, 1'b1, {(SRC_FRAC_W-1){1'b0}}};
  localparam logic [DST_W-1:0] DST_QNAN = {1'b0, EXP_ONES, 1'b1, {(DST_FRAC_W-1){1'b0}}};
  localparam logic [DST_W-2:0] MAX_MAG  = {EXP_ONES - 1'b1, {DST_FRAC_W{1'b1}}};
  localparam logic [DST_W-2:0] INF_MAG  = {EXP_ONES, {DST_FRAC_W{1'b0}}};

  function automatic logic decideUp(cvtCtrl_t c, logic s, logic l, logic g, logic t);
    return (c.modeRne & g & (t | l)) |
           (c.modeRmm & g) |
           (c.modeRdn & s & (g | t)) |
           (c.modeRup & ~s & (g | t));
  endfunction

  logic [SRC_W-1:0]      opBits;
  logic                  sgn;
  logic [EXP_W-1:0]      expo;
  logic [SRC_FRAC_W-1:0] frac;
  logic                  isNan, isSnan, isInf, isZero;
  logic                  grd, stk, roundUp, roundUpUnb;
  logic [DST_W-1:0]      magSum;
  logic                  ovf, ovfToInf, tiny, lostBits;
  logic [DST_W-1:0]      nextRes;
  logic                  nextNv, nextOf, nextUf, nextNx;

  always_comb begin
    opBits   = ctrl.boxFail ? SRC_QNAN : operand;
    sgn      = opBits[SRC_W-1];
    expo     = opBits[SRC_W-2 -: EXP_W];
    frac     = opBits[SRC_FRAC_W-1:0];
    isNan    = (expo == EXP_ONES) && (frac != '0);
    isSnan   = isNan && !frac[SRC_FRAC_W-1];
    isInf    = (expo == EXP_ONES) && (frac == '0);
    isZero   = (expo == '0) && (frac == '0);
    grd      = frac[DROP_W-1];
    stk      = |frac[DROP_W-2:0];
    lostBits = grd | stk;
    roundUp  = decideUp(ctrl, sgn, frac[DROP_W], grd, stk);
    magSum   = {1'b0, opBits[SRC_W-2:DROP_W]} + {{(DST_W-1){1'b0}}, roundUp};
    ovf      = (magSum[DST_W-2 -: EXP_W] == EXP_ONES);
    ovfToInf = ctrl.modeRne | ctrl.modeRmm | (ctrl.modeRup & ~sgn) | (ctrl.modeRdn & sgn);
    // unbounded-exponent rounding: only leading-bit-at-top subnormals can reach the normal range
    roundUpUnb = decideUp(ctrl, sgn, frac[DROP_W-1], frac[DROP_W-2], |frac[DROP_W-3:0]);
    tiny     = (expo == '0) &&
               !((&frac[SRC_FRAC_W-1 -: DST_FRAC_W+1]) && roundUpUnb);

    nextRes = '0;
    nextNv  = 1'b0;
    nextOf  = 1'b0;
    nextUf  = 1'b0;
    nextNx  = 1'b0;
    if (ctrl.illegal) begin
      nextRes = '0;
    end else if (isNan) begin
      nextRes = DST_QNAN;
      nextNv  = isSnan;
    end else if (isInf || isZero) begin
      nextRes = {sgn, opBits[SRC_W-2:DROP_W]};
    end else if (ovf) begin
      nextRes = {sgn, ovfToInf ? INF_MAG : MAX_MAG};
      nextOf  = 1'b1;
      nextNx  = 1'b1;
    end else begin
      nextRes = {sgn, magSum[DST_W-2:0]};
      nextNx  = lostBits;
      nextUf  = tiny && lostBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outResult     <= '0;
      flagInvalid   <= 1'b0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInexact   <= 1'b0;
      illegalMode   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outResult     <= nextRes;
        flagInvalid   <= nextNv;
        flagOverflow  <= nextOf;
        flagUnderflow <= nextUf;
        flagInexact   <= nextNx;
        illegalMode   <= ctrl.illegal;
      end
    end
  end

  // R6: any NaN pattern on the output must be the canonical one
  a_r6_nan_canonical: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outResult[DST_W-2 -: EXP_W] == EXP_ONES && outResult[DST_FRAC_W-1:0] != '0)
      |-> outResult == DST_QNAN);
  // R5: underflow never without inexact
  a_r5_uf_needs_nx: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> flagInexact);
  // R3: overflow carries inexact and excludes underflow
  a_r3_of_needs_nx: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> (flagInexact && !flagUnderflow));
  // R2: illegal code keeps flags quiet
  a_r2_illegal_silent: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> !(flagInvalid || flagOverflow || flagUnderflow || flagInexact));
  // R2: a legal code selects exactly one rounding strobe
  a_r2_mode_onehot: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.illegal |-> $onehot({ctrl.modeRne, ctrl.modeRtz, ctrl.modeRdn, ctrl.modeRup, ctrl.modeRmm}));
  // R11: valid follows the strobe one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outResult)));
endmodule

// File: rtl/bf16_narrow_cvt.sv
module bf16_narrow_cvt
  import bfcvt_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [REG_W-1:0] inData,
  input  logic             boxCheckEn,
  input  logic [2:0]       rmField,
  input  logic [2:0]       dynMode,
  output logic             outValid,
  output logic [15:0]      outResult,
  output logic             flagInvalid,
  output logic             flagDivZero,
  output logic             flagOverflow,
  output logic             flagUnderflow,
  output logic             flagInexact,
  output logic             illegalMode
);
  cvtCtrl_t ctrl;

  bfcvt_control #(.REG_W(REG_W)) u_ctrl (
    .inData     (inData),
    .boxCheckEn (boxCheckEn),
    .rmField    (rmField),
    .dynMode    (dynMode),
    .ctrl       (ctrl)
  );

  bfcvt_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .operand       (inData[SRC_W-1:0]),
    .ctrl          (ctrl),
    .outValid      (outValid),
    .outResult     (outResult),
    .flagInvalid   (flagInvalid),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact),
    .illegalMode   (illegalMode)
  );

  // R9: no division happens here
  assign flagDivZero = 1'b0;
endmodule

// File: tb/bf16_narrow_cvt_tb.sv
module bf16_narrow_cvt_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic        boxCheckEn = 1'b0;
  logic [2:0]  rmField = '0;
  logic [2:0]  dynMode = '0;
  logic        outValid;
  logic [15:0] outResult;
  logic        flagInvalid, flagDivZero, flagOverflow, flagUnderflow, flagInexact, illegalMode;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bf16_narrow_cvt #(.REG_W(64)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .boxCheckEn(boxCheckEn), .rmField(rmField), .dynMode(dynMode),
    .outValid(outValid), .outResult(outResult),
    .flagInvalid(flagInvalid), .flagDivZero(flagDivZero), .flagOverflow(flagOverflow),
    .flagUnderflow(flagUnderflow), .flagInexact(flagInexact), .illegalMode(illegalMode)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // reference: {illegal, nv, dz, of, uf, nx, result[15:0]}
  function automatic logic [21:0] refModel(logic [63:0] r, logic en, logic [2:0] rm, logic [2:0] dyn);
    logic [2:0]  mode;
    logic [31:0] v;
    logic        s, up, upU, nx, uf, tiny;
    logic [15:0] rem, mag;
    logic [14:0] trunc;
    logic [22:0] f;
    logic [7:0]  e;
    int          p;
    logic [31:0] sig, low, halfU;
    mode = (rm == 3'd7) ? dyn : rm;
    if (mode > 3'd4) return {1'b1, 5'b0, 16'h0000};
    v = (en && r[63:32] != 32'hFFFF_FFFF) ? 32'h7FC0_0000 : r[31:0];
    s = v[31]; e = v[30:23]; f = v[22:0];
    if (e == 8'hFF && f != 0) return {1'b0, !f[22], 4'b0, 16'h7FC0};
    if (f == 0 && (e == 8'hFF || e == 8'h00)) return {6'b0, v[31:16]};
    trunc = v[30:16]; rem = v[15:0];
    case (mode)
      3'd0: up = (rem > 16'h8000) || (rem == 16'h8000 && trunc[0]);
      3'd1: up = 1'b0;
      3'd2: up = s && rem != 0;
      3'd3: up = !s && rem != 0;
      default: up = (rem >= 16'h8000);
    endcase
    nx = (rem != 0);
    mag = {1'b0, trunc} + {15'b0, up};
    if (mag >= 16'h7F80) begin
      if (mode == 3'd0 || mode == 3'd4 || (mode == 3'd3 && !s) || (mode == 3'd2 && s))
        return {3'b0, 1'b1, 1'b0, 1'b1, s, 15'h7F80};
      return {3'b0, 1'b1, 1'b0, 1'b1, s, 15'h7F7F};
    end
    tiny = 1'b0;
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 23; i++) if (f[i]) p = i;
      tiny = 1'b1;
      if (p >= 7) begin
        sig   = 32'(f) >> (p - 7);
        low   = 32'(f) & ((32'd1 << (p - 7)) - 1);
        halfU = (p > 7) ? (32'd1 << (p - 8)) : 32'd0;
        case (mode)
          3'd0: upU = (p > 7) && (low > halfU || (low == halfU && sig[0]));
          3'd1: upU = 1'b0;
          3'd2: upU = s && low != 0;
          3'd3: upU = !s && low != 0;
          default: upU = (p > 7) && (low >= halfU);
        endcase
        if (p == 22 && sig + 32'(upU) == 32'd256) tiny = 1'b0;
      end
    end
    uf = tiny && nx;
    return {3'b0, 1'b0, uf, nx, s, mag[14:0]};
  endfunction

  function automatic string pickTag(logic [63:0] r, logic en, logic [21:0] ex);
    if (ex[21]) return "R2";
    if (en && r[63:32] != 32'hFFFF_FFFF) return "R10";
    if (r[30:23] == 8'hFF && r[22:0] != 0) return "R6";
    if (r[22:0] == 0 && (r[30:23] == 8'hFF || r[30:23] == 0)) return "R7";
    if (ex[19]) return "R3";
    if (r[30:23] == 0) return "R5";
    return "R1";
  endfunction

  task automatic applyVec(logic [63:0] r, logic en, logic [2:0] rm, logic [2:0] dyn, string tag);
    logic [21:0] ex;
    logic [21:0] act;
    logic        bad;
    ex = refModel(r, en, rm, dyn);
    inData = r; boxCheckEn = en; rmField = rm; dynMode = dyn; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    act = {illegalMode, flagInvalid, flagDivZero, flagOverflow, flagUnderflow, flagInexact, outResult};
    checks = checks + 1;
    if (ex[21]) bad = !outValid || act[21:16] != ex[21:16];
    else        bad = !outValid || act != ex;
    if (bad) begin
      fails = fails + 1;
      $display("FAIL %s (R9 dz incl.) in=%h rm=%0d dyn=%0d: actual %h expected %h",
               tag, r[31:0], rm, dyn, act, ex);
    end
  endtask

  task automatic check1(logic cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (!cond) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam logic [31:0] BOX = 32'hFFFF_FFFF;

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1(!outValid && outResult == 16'h0 && !flagInexact, "R11 reset state",
           {15'b0, outValid, outResult}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 nearest-even ties and normal rounding
    applyVec({BOX, 32'h3F80_8000}, 1'b0, 3'd0, 3'd0, "R1 tie to even down");
    applyVec({BOX, 32'h3F81_8000}, 1'b0, 3'd0, 3'd0, "R1 tie to even up");
    applyVec({BOX, 32'h7F7F_0000}, 1'b0, 3'd0, 3'd0, "R1 exact max finite");
    // R2 modes
    applyVec({BOX, 32'h3F80_8001}, 1'b0, 3'd1, 3'd0, "R2 toward zero");
    applyVec({BOX, 32'h3F80_8001}, 1'b0, 3'd3, 3'd0, "R2 toward plus");
    applyVec({BOX, 32'hBF80_8001}, 1'b0, 3'd2, 3'd0, "R2 toward minus");
    applyVec({BOX, 32'h3F80_8000}, 1'b0, 3'd4, 3'd0, "R2 ties away");
    applyVec({BOX, 32'h3F80_0001}, 1'b0, 3'd7, 3'd3, "R2 dynamic up");
    applyVec({BOX, 32'h3F80_0001}, 1'b0, 3'd5, 3'd0, "R2 illegal 101");
    applyVec({BOX, 32'h3F80_0001}, 1'b0, 3'd7, 3'd6, "R2 illegal dynamic");
    // R3 overflow
    applyVec({BOX, 32'h7F7F_FFFF}, 1'b0, 3'd0, 3'd0, "R3 overflow nearest");
    applyVec({BOX, 32'h7F7F_FFFF}, 1'b0, 3'd1, 3'd0, "R3 overflow to zero");
    applyVec({BOX, 32'hFF7F_FFFF}, 1'b0, 3'd3, 3'd0, "R3 neg overflow up");
    applyVec({BOX, 32'hFF7F_FFFF}, 1'b0, 3'd2, 3'd0, "R3 neg overflow down");
    // R4/R5 subnormals and tininess
    applyVec({BOX, 32'h0001_0000}, 1'b0, 3'd0, 3'd0, "R4 exact subnormal");
    applyVec({BOX, 32'h0000_0001}, 1'b0, 3'd0, 3'd0, "R5 tiny to zero");
    applyVec({BOX, 32'h0000_0001}, 1'b0, 3'd3, 3'd0, "R4 smallest subnormal up");
    applyVec({BOX, 32'h007F_8000}, 1'b0, 3'd0, 3'd0, "R5 rounds to normal yet tiny");
    applyVec({BOX, 32'h007F_C000}, 1'b0, 3'd0, 3'd0, "R5 not tiny");
    applyVec({BOX, 32'h007F_FFFF}, 1'b0, 3'd0, 3'd0, "R5 not tiny full");
    // R6 NaNs
    applyVec({BOX, 32'h7FC0_0001}, 1'b0, 3'd0, 3'd0, "R6 quiet NaN");
    applyVec({BOX, 32'hFF80_0001}, 1'b0, 3'd0, 3'd0, "R6 signalling NaN");
    // R7 zeros and infinities
    applyVec({BOX, 32'h8000_0000}, 1'b0, 3'd0, 3'd0, "R7 negative zero");
    applyVec({BOX, 32'hFF80_0000}, 1'b0, 3'd0, 3'd0, "R7 negative inf");
    // R8 inexact
    applyVec({BOX, 32'h3F80_0001}, 1'b0, 3'd1, 3'd0, "R8 inexact truncation");
    // R10 NaN boxing
    applyVec({32'hFFFF_FFFE, 32'h3F80_0000}, 1'b1, 3'd0, 3'd0, "R10 bad box");
    applyVec({32'h0000_0000, 32'h3F80_0000}, 1'b0, 3'd0, 3'd0, "R10 check off");
    applyVec({BOX, 32'h3F80_0000}, 1'b1, 3'd0, 3'd0, "R10 good box");

    // R11 idle hold
    held = outResult;
    inValid = 1'b0;
    inData = {BOX, 32'h4000_0000};
    @(posedge clk);
    @(negedge clk);
    check1(!outValid && outResult == held, "R11 idle hold", {15'b0, outValid, outResult}, {16'b0, held});

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      logic [63:0] r;
      logic        en;
      w = $urandom;
      case ($urandom % 6)
        0: w[30:23] = 8'hFE;
        1: w[30:23] = 8'h00;
        2: begin w[30:23] = 8'h00; w[22:15] = 8'hFF; end
        3: w[30:23] = 8'hFF;
        default: ;
      endcase
      en = ($urandom % 4) == 0;
      r = {(($urandom % 3) == 0) ? 32'($urandom) : BOX, w};
      applyVec(r, en, 3'($urandom % 8), 3'($urandom % 8), pickTag(r, en, refModel(r, en, 3'd0, 3'd0)));
    end

    inValid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule